// File: doc/BRIEF.md
# Eight-Bit Accumulator ALU with Nibble Flags

This block is the arithmetic and logic stage of a small accumulator datapath, and it holds no state. It takes the accumulator value, a second operand, the current carry flag and a 4-bit operation code. Within the same cycle it returns an 8-bit result, a write strobe for the accumulator, and four flag values with a matching update mask.

Flag bus bit positions are [3] zero, [2] subtract, [1] half-carry and [0] carry. A flag whose mask bit is 0 must keep its old value in the flag register outside the block, and its value bit reads 0. The half-carry flag records the carry or borrow between the low and high nibble.

Top module: `alu8_core`

## Requirements
- R1: Code 0 (add) gives acc+opd and code 1 (add with carry) gives acc+opd+carry_i. Both write the accumulator, update all four flags, and set z, n=0, h = carry out of bit 3, and c = carry out of bit 7. carry_i is ignored for code 0.
- R2: Code 2 (subtract) gives acc-opd and code 3 (subtract with borrow) gives acc-opd-carry_i. Both write the accumulator and update all flags. n=1, h is set on a borrow into bit 4, and c is set when opd plus borrow exceeds acc as unsigned values.
- R3: Code 7 (compare) drives result_o with acc-opd and sets all four flags as code 2 does, but acc_we_o stays 0.
- R4: Code 4 (and) writes acc&opd with flags z,0,1,0. Code 5 (xor) and code 6 (or) write their results with flags z,0,0,0. All four flags are updated.
- R5: Code 8 (increment) writes acc+1 and code 9 (decrement) writes acc-1. The mask is 4'b1110, so carry is not updated, and opd_i and carry_i are ignored. n is 0 for increment and 1 for decrement, and h follows R1 or R2.
- R6: Code 10 (complement) writes ~acc and sets n=1 and h=1 with mask 4'b0110.
- R7: Code 11 (set carry) and code 12 (complement carry) leave the accumulator unwritten, drive result_o with acc, and use mask 4'b0111 with n=0 and h=0. c is 1 for code 11 and ~carry_i for code 12.
- R8: Whenever the zero flag is updated, it is 1 exactly when result_o is 8'h00.
- R9: Every flag bit whose mask bit is 0 reads 0 on flag_o.
- R10: Codes 13 to 15 are reserved. For these codes acc_we_o is 0, the mask is 0, and result_o equals acc_i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| acc_i | input | 8 | Accumulator operand |
| opd_i | input | 8 | Second operand |
| carry_i | input | 1 | Current carry flag |
| op_i | input | 4 | Operation code |
| result_o | output | 8 | Operation result |
| acc_we_o | output | 1 | Accumulator write strobe |
| flag_o | output | 4 | Flag values {z,n,h,c} |
| flag_upd_o | output | 4 | Per-flag update mask {z,n,h,c} |

## Verification
The assertions sample the outputs only after the combinational inputs have settled. They assume op_i always holds a defined 4-bit value, and reserved codes are allowed. The bench changes inputs only at one point in each step and samples one time unit later. A table of hand-computed vectors covers every code and each carry, borrow and zero boundary. Two exhaustive sweeps then cover add-with-carry and subtract-with-borrow over every operand pair, checked against an arithmetic model kept in the bench.

// File: rtl/alu8_pkg.sv
package alu8_pkg;

  typedef enum logic [3:0] {
    OP_ADD = 4'd0,
    OP_ADC = 4'd1,
    OP_SUB = 4'd2,
    OP_SBC = 4'd3,
    OP_AND = 4'd4,
    OP_XOR = 4'd5,
    OP_OR  = 4'd6,
    OP_CMP = 4'd7,
    OP_INC = 4'd8,
    OP_DEC = 4'd9,
    OP_CPL = 4'd10,
    OP_SCF = 4'd11,
    OP_CCF = 4'd12,
    OP_R13 = 4'd13,
    OP_R14 = 4'd14,
    OP_R15 = 4'd15
  } alu_op_e;

  typedef enum logic [1:0] { RES_ARITH, RES_LOGIC, RES_ACC } res_src_e;
  typedef enum logic [1:0] { HF_ZERO, HF_ONE, HF_ARITH } hf_src_e;
  typedef enum logic [1:0] { CF_ZERO, CF_ONE, CF_ARITH, CF_INV } cf_src_e;
  typedef enum logic [1:0] { LG_AND, LG_XOR, LG_OR, LG_NOT } lg_op_e;

  typedef struct packed {
    logic     sub;       // arithmetic unit subtracts
    logic     b_zero;    // use zero instead of operand
    logic     cin_one;   // force carry-in to 1
    logic     cin_use;   // take carry-in from carry_i
    lg_op_e   lg;
    res_src_e res;
    logic     we;
    logic     n_val;
    hf_src_e  hsrc;
    cf_src_e  csrc;
    logic [3:0] mask;    // {z,n,h,c}
  } alu_ctrl_t;

endpackage

// File: rtl/alu8_decode.sv
module alu8_decode
  import alu8_pkg::*;
(
  input  logic [3:0] op_i,
  output alu_ctrl_t  ctrl_o
);

  always_comb begin
    ctrl_o = '{sub: 1'b0, b_zero: 1'b0, cin_one: 1'b0, cin_use: 1'b0,
               lg: LG_AND, res: RES_ACC, we: 1'b0, n_val: 1'b0,
               hsrc: HF_ZERO, csrc: CF_ZERO, mask: 4'b0000};
    case (alu_op_e'(op_i))
      OP_ADD, OP_ADC: begin
        ctrl_o.cin_use = (alu_op_e'(op_i) == OP_ADC);
        ctrl_o.res  = RES_ARITH;
        ctrl_o.we   = 1'b1;
        ctrl_o.hsrc = HF_ARITH;
        ctrl_o.csrc = CF_ARITH;
        ctrl_o.mask = 4'b1111;
      end
      OP_SUB, OP_SBC, OP_CMP: begin
        ctrl_o.sub     = 1'b1;
        ctrl_o.cin_use = (alu_op_e'(op_i) == OP_SBC);
        ctrl_o.res     = RES_ARITH;
        ctrl_o.we      = (alu_op_e'(op_i) != OP_CMP);
        ctrl_o.n_val   = 1'b1;
        ctrl_o.hsrc    = HF_ARITH;
        ctrl_o.csrc    = CF_ARITH;
        ctrl_o.mask    = 4'b1111;
      end
      OP_AND, OP_XOR, OP_OR: begin
        ctrl_o.lg   = (alu_op_e'(op_i) == OP_AND) ? LG_AND :
                      (alu_op_e'(op_i) == OP_XOR) ? LG_XOR : LG_OR;
        ctrl_o.res  = RES_LOGIC;
        ctrl_o.we   = 1'b1;
        ctrl_o.hsrc = (alu_op_e'(op_i) == OP_AND) ? HF_ONE : HF_ZERO;
        ctrl_o.mask = 4'b1111;
      end
      OP_INC, OP_DEC: begin
        ctrl_o.sub     = (alu_op_e'(op_i) == OP_DEC);
        ctrl_o.b_zero  = 1'b1;
        ctrl_o.cin_one = 1'b1;
        ctrl_o.res     = RES_ARITH;
        ctrl_o.we      = 1'b1;
        ctrl_o.n_val   = (alu_op_e'(op_i) == OP_DEC);
        ctrl_o.hsrc    = HF_ARITH;
        ctrl_o.mask    = 4'b1110;
      end
      OP_CPL: begin
        ctrl_o.lg    = LG_NOT;
        ctrl_o.res   = RES_LOGIC;
        ctrl_o.we    = 1'b1;
        ctrl_o.n_val = 1'b1;
        ctrl_o.hsrc  = HF_ONE;
        ctrl_o.mask  = 4'b0110;
      end
      OP_SCF, OP_CCF: begin
        ctrl_o.csrc = (alu_op_e'(op_i) == OP_SCF) ? CF_ONE : CF_INV;
        ctrl_o.mask = 4'b0111;
      end
      default: ;
    endcase
  end

endmodule

// File: rtl/alu8_addsub.sv
module alu8_addsub #(
  parameter int DW = 8
) (
  input  logic [DW-1:0] a_i,
  input  logic [DW-1:0] b_i,
  input  logic          cin_i,
  input  logic          sub_i,
  output logic [DW-1:0] sum_o,
  output logic          half_o,
  output logic          carry_o
);

  localparam int NB = DW / 2;

  logic [NB:0] lo_q;
  logic [NB:0] hi_q;

  // Two chained nibble stages: the low stage's top bit is the half
  // carry (or borrow) and feeds the high stage.
  always_comb begin
    if (sub_i) begin
      lo_q = {1'b0, a_i[NB-1:0]} - {1'b0, b_i[NB-1:0]} - {{NB{1'b0}}, cin_i};
      hi_q = {1'b0, a_i[DW-1:NB]} - {1'b0, b_i[DW-1:NB]} - {{NB{1'b0}}, lo_q[NB]};
    end else begin
      lo_q = {1'b0, a_i[NB-1:0]} + {1'b0, b_i[NB-1:0]} + {{NB{1'b0}}, cin_i};
      hi_q = {1'b0, a_i[DW-1:NB]} + {1'b0, b_i[DW-1:NB]} + {{NB{1'b0}}, lo_q[NB]};
    end
  end

  assign sum_o   = {hi_q[NB-1:0], lo_q[NB-1:0]};
  assign half_o  = lo_q[NB];
  assign carry_o = hi_q[NB];

endmodule

// File: rtl/alu8_bitwise.sv
module alu8_bitwise
  import alu8_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic [DW-1:0] a_i,
  input  logic [DW-1:0] b_i,
  input  lg_op_e        lg_i,
  output logic [DW-1:0] y_o
);

  always_comb begin
    case (lg_i)
      LG_AND:  y_o = a_i & b_i;
      LG_XOR:  y_o = a_i ^ b_i;
      LG_OR:   y_o = a_i | b_i;
      default: y_o = ~a_i;
    endcase
  end

endmodule

// File: rtl/alu8_core.sv
module alu8_core
  import alu8_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic [DW-1:0] acc_i,
  input  logic [DW-1:0] opd_i,
  input  logic          carry_i,
  input  logic [3:0]    op_i,
  output logic [DW-1:0] result_o,
  output logic          acc_we_o,
  output logic [3:0]    flag_o,
  output logic [3:0]    flag_upd_o
);

  localparam int FZ = 3;
  localparam int FN = 2;
  localparam int FH = 1;
  localparam int FC = 0;

  alu_ctrl_t     ctrl;
  logic [DW-1:0] b_sel;
  logic          cin_sel;
  logic [DW-1:0] arith_y;
  logic          arith_h;
  logic          arith_c;
  logic [DW-1:0] logic_y;
  logic [3:0]    raw_flags;

  alu8_decode u_dec (
    .op_i   (op_i),
    .ctrl_o (ctrl)
  );

  assign b_sel   = ctrl.b_zero ? '0 : opd_i;
  assign cin_sel = ctrl.cin_one | (ctrl.cin_use & carry_i);

  alu8_addsub #(.DW(DW)) u_arith (
    .a_i     (acc_i),
    .b_i     (b_sel),
    .cin_i   (cin_sel),
    .sub_i   (ctrl.sub),
    .sum_o   (arith_y),
    .half_o  (arith_h),
    .carry_o (arith_c)
  );

  alu8_bitwise #(.DW(DW)) u_logic (
    .a_i  (acc_i),
    .b_i  (opd_i),
    .lg_i (ctrl.lg),
    .y_o  (logic_y)
  );

  always_comb begin
    case (ctrl.res)
      RES_ARITH: result_o = arith_y;
      RES_LOGIC: result_o = logic_y;
      default:   result_o = acc_i;
    endcase

    raw_flags[FZ] = (result_o == '0);
    raw_flags[FN] = ctrl.n_val;
    case (ctrl.hsrc)
      HF_ONE:   raw_flags[FH] = 1'b1;
      HF_ARITH: raw_flags[FH] = arith_h;
      default:  raw_flags[FH] = 1'b0;
    endcase
    case (ctrl.csrc)
      CF_ONE:   raw_flags[FC] = 1'b1;
      CF_ARITH: raw_flags[FC] = arith_c;
      CF_INV:   raw_flags[FC] = ~carry_i;
      default:  raw_flags[FC] = 1'b0;
    endcase
  end

  assign flag_o     = raw_flags & ctrl.mask;
  assign flag_upd_o = ctrl.mask;
  assign acc_we_o   = ctrl.we;

  // Port-level checks on settled combinational outputs.
  always_comb begin
    a_r3_cmp_no_write: assert (!(op_i == OP_CMP && acc_we_o))
      else $error("compare wrote accumulator");
    a_r5_incdec_keep_carry: assert (!((op_i == OP_INC || op_i == OP_DEC) && flag_upd_o[FC]))
      else $error("inc/dec updated carry");
    a_r8_zero_matches: assert (!flag_upd_o[FZ] || (flag_o[FZ] == (result_o == '0)))
      else $error("zero flag mismatch");
    a_r9_masked_low: assert ((flag_o & ~flag_upd_o) == 4'b0000)
      else $error("unmasked flag bit high");
    a_r10_reserved_idle: assert (!(op_i >= OP_R13 && (acc_we_o || flag_upd_o != 4'b0000)))
      else $error("reserved code had effect");
    a_r4_logic_carry_clear: assert (!((op_i == OP_AND || op_i == OP_XOR || op_i == OP_OR) &&
                                      flag_o[FC]))
      else $error("logic op set carry");
  end

endmodule

// File: tb/tb_alu8_core.sv
module tb_alu8_core;

  logic       clk;
  logic       rst_n;
  logic [7:0] acc;
  logic [7:0] opd;
  logic       cin;
  logic [3:0] op;
  logic [7:0] res;
  logic       we;
  logic [3:0] flg;
  logic [3:0] msk;

  int checks   = 0;
  int failures = 0;
  int cycles   = 0;
  bit done     = 0;

  alu8_core dut (
    .acc_i      (acc),
    .opd_i      (opd),
    .carry_i    (cin),
    .op_i       (op),
    .result_o   (res),
    .acc_we_o   (we),
    .flag_o     (flg),
    .flag_upd_o (msk)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 100000 && !done) begin
      failures = failures + 1;
      checks   = checks + 1;
      $display("FAIL watchdog expired act=%0d exp<100000", cycles);
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  // {req, op, acc, opd, cin, res, we, flags, mask}
  localparam int NV = 26;
  localparam logic [41:0] VEC [NV] = '{
    {4'd1,  4'd0,  8'h3A, 8'hC6, 1'b0, 8'h00, 1'b1, 4'b1011, 4'b1111}, // R1 wrap to zero
    {4'd1,  4'd1,  8'h0F, 8'h00, 1'b1, 8'h10, 1'b1, 4'b0010, 4'b1111}, // R1 carry into nibble
    {4'd1,  4'd0,  8'h0F, 8'h00, 1'b1, 8'h0F, 1'b1, 4'b0000, 4'b1111}, // R1 cin ignored
    {4'd2,  4'd2,  8'h3E, 8'h3E, 1'b0, 8'h00, 1'b1, 4'b1100, 4'b1111}, // R2 equal
    {4'd2,  4'd2,  8'h3E, 8'h0F, 1'b0, 8'h2F, 1'b1, 4'b0110, 4'b1111}, // R2 half borrow
    {4'd2,  4'd2,  8'h3E, 8'h40, 1'b0, 8'hFE, 1'b1, 4'b0101, 4'b1111}, // R2 full borrow
    {4'd2,  4'd3,  8'h3B, 8'h2A, 1'b1, 8'h10, 1'b1, 4'b0100, 4'b1111}, // R2 sbc no borrow
    {4'd2,  4'd3,  8'h00, 8'h00, 1'b1, 8'hFF, 1'b1, 4'b0111, 4'b1111}, // R2 sbc borrow only
    {4'd4,  4'd4,  8'h5A, 8'h3F, 1'b1, 8'h1A, 1'b1, 4'b0010, 4'b1111}, // R4 and
    {4'd4,  4'd4,  8'hF0, 8'h0F, 1'b0, 8'h00, 1'b1, 4'b1010, 4'b1111}, // R4 and zero
    {4'd4,  4'd5,  8'hFF, 8'hFF, 1'b1, 8'h00, 1'b1, 4'b1000, 4'b1111}, // R4 xor
    {4'd4,  4'd6,  8'h00, 8'h00, 1'b0, 8'h00, 1'b1, 4'b1000, 4'b1111}, // R4 or zero
    {4'd4,  4'd6,  8'h5A, 8'h0F, 1'b1, 8'h5F, 1'b1, 4'b0000, 4'b1111}, // R4 or
    {4'd3,  4'd7,  8'h3C, 8'h2F, 1'b0, 8'h0D, 1'b0, 4'b0110, 4'b1111}, // R3 compare less
    {4'd3,  4'd7,  8'h3C, 8'h3C, 1'b1, 8'h00, 1'b0, 4'b1100, 4'b1111}, // R3 compare equal
    {4'd5,  4'd8,  8'hFF, 8'hAA, 1'b1, 8'h00, 1'b1, 4'b1010, 4'b1110}, // R5 inc wrap
    {4'd5,  4'd8,  8'h50, 8'hAA, 1'b0, 8'h51, 1'b1, 4'b0000, 4'b1110}, // R5 inc
    {4'd5,  4'd9,  8'h01, 8'h55, 1'b0, 8'h00, 1'b1, 4'b1100, 4'b1110}, // R5 dec to zero
    {4'd5,  4'd9,  8'h00, 8'h55, 1'b1, 8'hFF, 1'b1, 4'b0110, 4'b1110}, // R5 dec wrap
    {4'd6,  4'd10, 8'h35, 8'h00, 1'b1, 8'hCA, 1'b1, 4'b0110, 4'b0110}, // R6 complement
    {4'd7,  4'd11, 8'h12, 8'h00, 1'b0, 8'h12, 1'b0, 4'b0001, 4'b0111}, // R7 set carry
    {4'd7,  4'd12, 8'h12, 8'h00, 1'b1, 8'h12, 1'b0, 4'b0000, 4'b0111}, // R7 ccf 1->0
    {4'd7,  4'd12, 8'h00, 8'h00, 1'b0, 8'h00, 1'b0, 4'b0001, 4'b0111}, // R7 ccf 0->1
    {4'd10, 4'd13, 8'h77, 8'h11, 1'b1, 8'h77, 1'b0, 4'b0000, 4'b0000}, // R10 reserved
    {4'd10, 4'd14, 8'h00, 8'h11, 1'b0, 8'h00, 1'b0, 4'b0000, 4'b0000}, // R10 reserved
    {4'd10, 4'd15, 8'hA5, 8'h11, 1'b1, 8'hA5, 1'b0, 4'b0000, 4'b0000}  // R10 reserved
  };

  task automatic check(input int req, input string what, input logic [15:0] act,
                       input logic [15:0] exp);
    checks = checks + 1;
    if (act !== exp) begin
      failures = failures + 1;
      $display("FAIL R%0d %s act=%h exp=%h", req, what, act, exp);
    end
  endtask

  task automatic check_all(input int req, input logic [7:0] e_res, input logic e_we,
                           input logic [3:0] e_flg, input logic [3:0] e_msk);
    check(req, "result", {8'h00, res}, {8'h00, e_res});
    check(req, "acc_we", {15'h0, we}, {15'h0, e_we});
    check(req, "flags", {12'h0, flg}, {12'h0, e_flg});
    check(req, "mask", {12'h0, msk}, {12'h0, e_msk});
  endtask

  initial begin
    rst_n = 1'b0;
    acc = 8'h00; opd = 8'h00; cin = 1'b0; op = 4'd0;
    repeat (3) @(negedge clk);
    // Idle inputs during reset: add of zeros. R8: zero flag set, R9: all mask bits high
    check_all(8, 8'h00, 1'b1, 4'b1000, 4'b1111);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      @(posedge clk);
      #1;
      op  = VEC[i][37:34];
      acc = VEC[i][33:26];
      opd = VEC[i][25:18];
      cin = VEC[i][17];
      @(negedge clk);
      check_all(int'(VEC[i][41:38]), VEC[i][16:9], VEC[i][8], VEC[i][7:4], VEC[i][3:0]);
    end

    // R1 sweep: add with carry over every operand pair, carry in set.
    op = 4'd1; cin = 1'b1;
    for (int a = 0; a < 256; a++) begin
      for (int b = 0; b < 256; b++) begin
        int s;
        logic [3:0] ef;
        acc = 8'(a); opd = 8'(b);
        #1;
        s = a + b + 1;
        ef = {(s % 256) == 0, 1'b0, ((a % 16) + (b % 16) + 1) > 15, s > 255};
        if (res !== 8'(s) || flg !== ef) begin
          check(1, "adc sweep", {res, 4'h0, flg}, {8'(s), 4'h0, ef});
        end else checks = checks + 1;
        #1;
      end
    end

    // R2 sweep: subtract with borrow over every operand pair, borrow in set.
    op = 4'd3; cin = 1'b1;
    for (int a = 0; a < 256; a++) begin
      for (int b = 0; b < 256; b++) begin
        int d;
        logic [3:0] ef;
        acc = 8'(a); opd = 8'(b);
        #1;
        d = a - b - 1;
        ef = {((d + 512) % 256) == 0, 1'b1, (a % 16) < ((b % 16) + 1), a < (b + 1)};
        if (res !== 8'(d + 512) || flg !== ef) begin
          check(2, "sbc sweep", {res, 4'h0, flg}, {8'(d + 512), 4'h0, ef});
        end else checks = checks + 1;
        #1;
      end
    end

    done = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule